// File: doc/BRIEF.md
# Tagged Register Status File

This block holds the architectural registers of an out-of-order core, with a producer tag stored beside each value. The tag says whether the register's value can be trusted. A null tag means the value is current. A non-null tag names the reservation station that will produce the next value.

The issue stage reads two source registers each cycle. For each one it gets either a usable value or the tag of the producer it must wait for. In the same cycle the issue stage can rename one destination register by writing the issuing station's tag into it. A result bus delivers at most one tag/value pair per cycle. Every register whose tag matches that pair takes the value and becomes valid. A register whose tag has since been overwritten by a younger writer ignores the older result.

A debug write port loads initial values. Reset clears every tag and every value.

Top module: `tagreg_file`

## Requirements
- R1: After reset every register reads with tag 0 (null) and value 0.
- R2: A debug write stores its data and clears the tag of that register; the new state is visible from the next cycle.
- R3: A source read of a register with tag 0 returns the stored value and tag 0.
- R4: A source read of a register with a non-zero tag returns that tag and a value of 0.
- R5: A rename writes the given station tag into the destination register from the next cycle on, even when the register already waits on another producer.
- R6: When the result bus is valid and its tag equals a register's non-zero tag, that register takes the bus value and clears its tag from the next cycle on.
- R7: A bus result whose tag does not equal the register's current tag leaves that register unchanged. A result with tag 0 never changes any register.
- R8: One bus result updates every register holding the matching tag, all in the same cycle.
- R9: If a rename and a matching bus result hit the same register in the same cycle, the rename wins and the result is dropped for that register.
- R10: A source read in the same cycle as a matching bus result returns the bus value with tag 0.
- R11: Source reads in the cycle of a rename see the register state from before that rename.
- R12: A debug write takes priority over a rename and over a bus result to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_idx | input | IDX_W | Register index for source read A |
| src_a_value | output | DATA_W | Value for read A, 0 while pending |
| src_a_tag | output | TAG_W | Producer tag for read A, 0 when valid |
| src_b_idx | input | IDX_W | Register index for source read B |
| src_b_value | output | DATA_W | Value for read B, 0 while pending |
| src_b_tag | output | TAG_W | Producer tag for read B, 0 when valid |
| dst_we | input | 1 | Rename strobe |
| dst_idx | input | IDX_W | Register to rename |
| dst_tag | input | TAG_W | Tag of the issuing station (non-zero) |
| res_valid | input | 1 | Result bus carries a pair this cycle |
| res_tag | input | TAG_W | Producer tag on the result bus |
| res_data | input | DATA_W | Result value on the result bus |
| dbg_we | input | 1 | Debug write strobe |
| dbg_idx | input | IDX_W | Debug write register index |
| dbg_data | input | DATA_W | Debug write value |

## Verification
A tag that is wrong inside the file shows at a source read port within one cycle of the update that produced it. The port then returns a value where it should return a producer tag, or a tag that is not the newest one. The bench runs a rename that is overwritten, followed by a stale result from the overwritten producer. It also runs one result that releases two registers at once, a rename and a result that collide on the same register, and a debug write that collides with a rename. The operand bypass is checked in the cycle of each result. The registered state is checked in the cycle after, so a missing bypass and a missing latch show up as separate failures.

// File: rtl/tagreg_pkg.sv
package tagreg_pkg;

    localparam int DEF_REGS   = 32;
    localparam int DEF_TAG_W  = 4;
    localparam int DEF_DATA_W = 32;

    // Which source updates a register in a given cycle, highest priority first
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_DEBUG  = 2'd1,
        UPD_RENAME = 2'd2,
        UPD_RESULT = 2'd3
    } upd_src_e;

    function automatic upd_src_e pick_update(input logic dbg, input logic ren, input logic hit);
        if (dbg)      return UPD_DEBUG;
        else if (ren) return UPD_RENAME;
        else if (hit) return UPD_RESULT;
        else          return UPD_NONE;
    endfunction

endpackage

// File: rtl/tagreg_cell.sv
module tagreg_cell
    import tagreg_pkg::*;
#(
    parameter int TAG_W  = DEF_TAG_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_sel,
    input  logic [DATA_W-1:0] dbg_data,
    input  logic              ren_sel,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [DATA_W-1:0] cur_value
);

    localparam logic [TAG_W-1:0] NULL_TAG = '0;

    logic     bus_hit;
    upd_src_e upd;

    assign bus_hit = res_valid && (cur_tag != NULL_TAG) && (res_tag == cur_tag);
    assign upd     = pick_update(dbg_sel, ren_sel, bus_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_tag   <= NULL_TAG;
            cur_value <= '0;
        end else begin
            unique case (upd)
                UPD_DEBUG: begin
                    cur_value <= dbg_data;
                    cur_tag   <= NULL_TAG;
                end
                UPD_RENAME: cur_tag <= ren_tag;
                UPD_RESULT: begin
                    cur_value <= res_data;
                    cur_tag   <= NULL_TAG;
                end
                default: ;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (cur_tag == NULL_TAG && cur_value == '0));

    // R12
    debug_load_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_sel |=> (cur_tag == NULL_TAG && cur_value == $past(dbg_data)));

    // R5
    rename_stamp_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_sel && !dbg_sel) |=> (cur_tag == $past(ren_tag) && $stable(cur_value)));

    // R6
    result_take_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && cur_tag != NULL_TAG && res_tag == cur_tag && !ren_sel && !dbg_sel)
        |=> (cur_tag == NULL_TAG && cur_value == $past(res_data)));

    // R7
    stale_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_tag != cur_tag && !ren_sel && !dbg_sel)
        |=> ($stable(cur_tag) && $stable(cur_value)));

endmodule

// File: rtl/tagreg_rdport.sv
module tagreg_rdport
    import tagreg_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int TAG_W    = DEF_TAG_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag_arr [NUM_REGS],
    input  logic [DATA_W-1:0] val_arr [NUM_REGS],
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] out_value,
    output logic [TAG_W-1:0]  out_tag
);

    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_val;
    logic              fwd;

    assign sel_tag = tag_arr[idx];
    assign sel_val = val_arr[idx];
    assign fwd     = res_valid && (sel_tag != '0) && (res_tag == sel_tag);

    always_comb begin
        if (fwd) begin
            out_value = res_data;
            out_tag   = '0;
        end else if (sel_tag != '0) begin
            out_value = '0;
            out_tag   = sel_tag;
        end else begin
            out_value = sel_val;
            out_tag   = '0;
        end
    end

endmodule

// File: rtl/tagreg_file.sv
module tagreg_file
    import tagreg_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int TAG_W    = DEF_TAG_W,
    parameter int DATA_W   = DEF_DATA_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              dst_we,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [TAG_W-1:0]  dst_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic              dbg_we,
    input  logic [IDX_W-1:0]  dbg_idx,
    input  logic [DATA_W-1:0] dbg_data
);

    logic [TAG_W-1:0]  tags [NUM_REGS];
    logic [DATA_W-1:0] vals [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic ren_hit;
        logic dbg_hit;
        assign ren_hit = dst_we && (dst_idx == IDX_W'(g));
        assign dbg_hit = dbg_we && (dbg_idx == IDX_W'(g));

        tagreg_cell #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .dbg_sel   (dbg_hit),
            .dbg_data  (dbg_data),
            .ren_sel   (ren_hit),
            .ren_tag   (dst_tag),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_data  (res_data),
            .cur_tag   (tags[g]),
            .cur_value (vals[g])
        );
    end

    tagreg_rdport #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_a (
        .idx       (src_a_idx),
        .tag_arr   (tags),
        .val_arr   (vals),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .out_value (src_a_value),
        .out_tag   (src_a_tag)
    );

    tagreg_rdport #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_b (
        .idx       (src_b_idx),
        .tag_arr   (tags),
        .val_arr   (vals),
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .out_value (src_b_value),
        .out_tag   (src_b_tag)
    );

    // R4
    pending_read_chk: assert property (@(posedge clk) disable iff (rst)
        (src_a_tag != '0) |-> (src_a_value == '0 && tags[src_a_idx] == src_a_tag));

    // R10
    bypass_read_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && tags[src_b_idx] != '0 && tags[src_b_idx] == res_tag)
        |-> (src_b_tag == '0 && src_b_value == res_data));

endmodule

// File: tb/tagreg_file_test.sv
module tagreg_file_test;

    localparam int NR = 32;
    localparam int TW = 4;
    localparam int DW = 32;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst;
    logic [IW-1:0] a_idx, b_idx, d_idx, g_idx;
    logic [DW-1:0] a_val, b_val, r_data, g_data;
    logic [TW-1:0] a_tag, b_tag, d_tag, r_tag;
    logic          d_we, r_valid, g_we;

    always #5 clk = ~clk;

    tagreg_file #(.NUM_REGS(NR), .TAG_W(TW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .src_a_idx(a_idx), .src_a_value(a_val), .src_a_tag(a_tag),
        .src_b_idx(b_idx), .src_b_value(b_val), .src_b_tag(b_tag),
        .dst_we(d_we), .dst_idx(d_idx), .dst_tag(d_tag),
        .res_valid(r_valid), .res_tag(r_tag), .res_data(r_data),
        .dbg_we(g_we), .dbg_idx(g_idx), .dbg_data(g_data)
    );

    typedef struct {
        logic [DW-1:0] av;
        logic [TW-1:0] at;
        logic [DW-1:0] bv;
        logic [TW-1:0] bt;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;

    // Driver: applies one cycle of stimulus and queues the read-port results it expects
    task automatic cyc(input int ra, input int rb,
                       input bit dw, input int di, input int dt,
                       input bit rv, input int rt, input int rd,
                       input bit gw, input int gi, input int gd,
                       input int eav, input int eat, input int ebv, input int ebt,
                       input string req);
        exp_t e;
        @(negedge clk);
        a_idx = IW'(ra); b_idx = IW'(rb);
        d_we = dw; d_idx = IW'(di); d_tag = TW'(dt);
        r_valid = rv; r_tag = TW'(rt); r_data = DW'(rd);
        g_we = gw; g_idx = IW'(gi); g_data = DW'(gd);
        e.av = DW'(eav); e.at = TW'(eat); e.bv = DW'(ebv); e.bt = TW'(ebt); e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: samples the read ports shortly after each stimulus change
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (a_val !== e.av || a_tag !== e.at || b_val !== e.bv || b_tag !== e.bt) begin
                    n_errors++;
                    $display("FAIL %s: A=%0d/t%0d B=%0d/t%0d expected A=%0d/t%0d B=%0d/t%0d",
                             e.req, a_val, a_tag, b_val, b_tag, e.av, e.at, e.bv, e.bt);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_idx = '0; b_idx = '0; d_we = 1'b0; d_idx = '0; d_tag = '0;
        r_valid = 1'b0; r_tag = '0; r_data = '0; g_we = 1'b0; g_idx = '0; g_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        //   ra rb  dw di dt  rv rt rd   gw gi gd   exp A      exp B
        cyc(3, 5,  0, 0, 0,  0, 0, 0,   1, 2, 6,   0, 0,      0, 0,  "R1 reset state");
        cyc(2, 3,  0, 0, 0,  0, 0, 0,   1, 3, 4,   6, 0,      0, 0,  "R2 debug load");
        cyc(3, 2,  0, 0, 0,  0, 0, 0,   1, 5, 1,   4, 0,      6, 0,  "R3 valid read");
        cyc(5, 1,  1, 1, 1,  0, 0, 0,   1, 6, 30,  1, 0,      0, 0,  "R3 read before rename");
        cyc(1, 6,  1, 1, 2,  0, 0, 0,   0, 0, 0,   0, 1,      30, 0, "R4 R11 pending read in rename cycle");
        cyc(1, 5,  1, 4, 3,  0, 0, 0,   0, 0, 0,   0, 2,      1, 0,  "R5 overwrite rename");
        cyc(1, 4,  1, 8, 2,  0, 0, 0,   0, 0, 0,   0, 2,      0, 3,  "R5 second rename");
        cyc(1, 8,  0, 0, 0,  1, 1, 24,  0, 0, 0,   0, 2,      0, 2,  "R7 stale result cycle");
        cyc(1, 6,  0, 0, 0,  0, 0, 0,   0, 0, 0,   0, 2,      30, 0, "R7 stale result dropped");
        cyc(1, 8,  0, 0, 0,  1, 2, 20,  0, 0, 0,   20, 0,     20, 0, "R10 bypass on result");
        cyc(1, 8,  0, 0, 0,  0, 0, 0,   0, 0, 0,   20, 0,     20, 0, "R6 R8 both registers released");
        cyc(4, 1,  1, 4, 5,  1, 3, 21,  0, 0, 0,   21, 0,     20, 0, "R11 bypass before colliding rename");
        cyc(4, 1,  0, 0, 0,  0, 0, 0,   0, 0, 0,   0, 5,      20, 0, "R9 rename beats result");
        cyc(9, 4,  1, 9, 6,  1, 5, 7,   0, 0, 0,   0, 0,      7, 0,  "R11 R10 rename and bypass");
        cyc(9, 4,  0, 0, 0,  0, 0, 0,   0, 0, 0,   0, 6,      7, 0,  "R5 R6 after rename and result");
        cyc(9, 3,  1, 9, 7,  1, 6, 11,  1, 9, 99,  11, 0,     4, 0,  "R12 collision cycle");
        cyc(9, 3,  0, 0, 0,  0, 0, 0,   0, 0, 0,   99, 0,     4, 0,  "R12 debug wins");
        cyc(3, 0,  0, 0, 0,  1, 0, 55,  0, 0, 0,   4, 0,      0, 0,  "R7 null-tag result cycle");
        cyc(3, 0,  0, 0, 0,  0, 0, 0,   0, 0, 0,   4, 0,      0, 0,  "R7 null-tag result ignored");
        @(negedge clk);
        r_valid = 1'b0; d_we = 1'b0; g_we = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule